// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Evaluator

This block applies one five-bit test vector to a small fixed gate network and evaluates it in many copies at once, one copy per bit lane of a machine word. Lane 0 carries the fault-free network. Each of the next eighteen lanes carries the same network with exactly one net held at a constant 0 or 1. Lanes above those are padding and also run fault-free. Each net is forced by a pair of per-net lane masks, an AND mask for stuck-at-0 and an OR mask for stuck-at-1. The masks act on the net before it feeds any later gate, so a fault spreads downstream only inside its own lane.

The network has primary inputs a, b, c, d and e. It computes f = b AND c, g = NOR(d, e), h = NAND(f, g) and the output i = a OR h. A vector is taken on any cycle where `vec_valid` is high. One cycle later the block presents three registered results, marked by `out_valid`: the per-lane output word, the mask of lanes whose output differs from the good lane, and a coverage mask. The coverage mask keeps the union of every detection mask since it was last cleared. A test program feeds candidate vectors and reads the coverage mask to see which faults its vector set exposes.

Top module: `fault_sim_eval`

## Requirements
- R1: After reset, `out_valid`, `out_word`, `det_mask` and `cov_mask` are all zero.
- R2: `vec_in[4]` is a, `vec_in[3]` is b, `vec_in[2]` is c, `vec_in[1]` is d and `vec_in[0]` is e. Lane 0 of `out_word` equals i of the fault-free network for that vector.
- R3: Nets are numbered a=0, b=1, c=2, d=3, e=4, f=5, g=6, h=7, i=8. Lane 2k+1 holds net k stuck at 0, and lane 2k+2 holds net k stuck at 1. Each such lane's output bit is i of the network with only that single fault applied.
- R4: Lanes 19 to 31 of `out_word` are fault-free and always equal lane 0.
- R5: `det_mask` is `out_word` XOR lane 0 copied to every lane. Its bit 0 and bits 19 to 31 are therefore always zero.
- R6: A vector taken at a clock edge appears on `out_word` and `det_mask` after that edge, with `out_valid` high for that one cycle. When no vector is taken, `out_valid` is low and `out_word` and `det_mask` hold their values.
- R7: Vector a..e = 0,1,1,0,0 sets `det_mask` bit 13, which is g stuck at 0. The fault-free output is 0 and the faulty lane outputs 1.
- R8: Without a clear, each accepted vector ORs its detection mask into `cov_mask` at the same edge that updates `det_mask`. Bits of `cov_mask` never fall without a clear.
- R9: `cov_clear` zeroes `cov_mask` at the next edge. If a vector is taken at that same edge, `cov_mask` becomes that vector's detection mask alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Test vector present this cycle |
| vec_in | input | 5 | Test vector, bit 4 = a down to bit 0 = e |
| cov_clear | input | 1 | Clear the coverage mask |
| out_valid | output | 1 | Results below belong to a vector taken at the last edge |
| out_word | output | 32 | Output net i in every lane |
| det_mask | output | 32 | Lanes whose output differs from lane 0 |
| cov_mask | output | 32 | Union of detection masks since the last clear |

## Verification
The bench applies all 32 input vectors in counting order and checks the whole output word and detection mask against a scalar fault-injection model for each. This separates a wrong lane order or a swapped stuck-at polarity from a wrong gate function, because each vector gives its own pattern of lanes that are sensitised. The vector 0,1,1,0,0 gets a dedicated check on the g stuck-at-0 lane. Back-to-back vectors followed by idle gaps show that results are taken only on valid cycles and held afterwards. A clear given alone and a clear given together with a vector show which of the two wins the coverage register.

// File: rtl/fse_pkg.sv
package fse_pkg;
   localparam int NUM_PI   = 5;
   localparam int NUM_NETS = 9;
   localparam int NUM_FAULT_LANES = 2 * NUM_NETS + 1;

   typedef enum int {
      NET_A = 0, NET_B = 1, NET_C = 2, NET_D = 3, NET_E = 4,
      NET_F = 5, NET_G = 6, NET_H = 7, NET_I = 8
   } net_e;

   function automatic int sa0_lane(int net);
      return 2 * net + 1;
   endfunction

   function automatic int sa1_lane(int net);
      return 2 * net + 2;
   endfunction
endpackage

// File: rtl/fse_fault_masks.sv
module fse_fault_masks #(
   parameter int WORD_W    = 32,
   parameter bit FAULTS_EN = 1'b1
) (
   output logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0] and_m,
   output logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0] or_m
);
   localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

   for (genvar k = 0; k < fse_pkg::NUM_NETS; k++) begin : g_net
      if (FAULTS_EN) begin : g_inject
         assign and_m[k] = ~(ONE << fse_pkg::sa0_lane(k));
         assign or_m[k]  =  (ONE << fse_pkg::sa1_lane(k));
      end else begin : g_neutral
         assign and_m[k] = '1;
         assign or_m[k]  = '0;
      end
   end
endmodule

// File: rtl/fse_lane_eval.sv
module fse_lane_eval #(
   parameter int WORD_W = 32
) (
   input  logic [fse_pkg::NUM_PI-1:0]                vec,
   input  logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0]  and_m,
   input  logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0]  or_m,
   output logic [WORD_W-1:0]                         i_word
);
   import fse_pkg::*;

   logic [NUM_PI-1:0][WORD_W-1:0]   pi_raw;
   logic [NUM_NETS-1:0][WORD_W-1:0] net;

   for (genvar p = 0; p < NUM_PI; p++) begin : g_pi
      assign pi_raw[p] = {WORD_W{vec[NUM_PI-1-p]}};
      assign net[p]    = (pi_raw[p] & and_m[p]) | or_m[p];
   end

   assign net[NET_F] = ((net[NET_B] & net[NET_C]) & and_m[NET_F]) | or_m[NET_F];
   assign net[NET_G] = (~(net[NET_D] | net[NET_E]) & and_m[NET_G]) | or_m[NET_G];
   assign net[NET_H] = (~(net[NET_F] & net[NET_G]) & and_m[NET_H]) | or_m[NET_H];
   assign net[NET_I] = ((net[NET_A] | net[NET_H]) & and_m[NET_I]) | or_m[NET_I];

   assign i_word = net[NET_I];
endmodule

// File: rtl/fse_result_reg.sv
module fse_result_reg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_valid,
   input  logic              cov_clear,
   input  logic [WORD_W-1:0] word_in,
   output logic              out_valid,
   output logic [WORD_W-1:0] word_q,
   output logic [WORD_W-1:0] det_q,
   output logic [WORD_W-1:0] cov_q
);
   logic [WORD_W-1:0] det_new;
   logic [WORD_W-1:0] cov_base;

   assign det_new  = word_in ^ {WORD_W{word_in[0]}};
   assign cov_base = cov_clear ? '0 : cov_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         word_q    <= '0;
         det_q     <= '0;
         cov_q     <= '0;
      end else begin
         out_valid <= vec_valid;
         if (vec_valid) begin
            word_q <= word_in;
            det_q  <= det_new;
         end
         cov_q <= cov_base | (vec_valid ? det_new : '0);
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> out_valid); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |=> (!out_valid && $stable(word_q) && $stable(det_q))); // R6
   AST_COV_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !cov_clear |=> ((cov_q & $past(cov_q)) == $past(cov_q))); // R8
   AST_DET_IN_COV: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((det_q & ~cov_q) == '0)); // R8
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (cov_clear && !vec_valid) |=> (cov_q == '0)); // R9
endmodule

// File: rtl/fault_sim_eval.sv
module fault_sim_eval #(
   parameter int WORD_W    = 32,
   parameter bit FAULTS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_valid,
   input  logic [4:0]        vec_in,
   input  logic              cov_clear,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic [WORD_W-1:0] det_mask,
   output logic [WORD_W-1:0] cov_mask
);
   localparam int NUM_LANES = fse_pkg::NUM_FAULT_LANES;

   if (WORD_W < NUM_LANES) begin : g_bad_width
      $error("fault_sim_eval: WORD_W must hold every fault lane");
   end

   logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0] and_m;
   logic [fse_pkg::NUM_NETS-1:0][WORD_W-1:0] or_m;
   logic [WORD_W-1:0]                        lane_word;

   fse_fault_masks #(.WORD_W(WORD_W), .FAULTS_EN(FAULTS_EN)) masks_i (
      .and_m (and_m),
      .or_m  (or_m)
   );

   fse_lane_eval #(.WORD_W(WORD_W)) eval_i (
      .vec    (vec_in),
      .and_m  (and_m),
      .or_m   (or_m),
      .i_word (lane_word)
   );

   fse_result_reg #(.WORD_W(WORD_W)) res_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_valid (vec_valid),
      .cov_clear (cov_clear),
      .word_in   (lane_word),
      .out_valid (out_valid),
      .word_q    (out_word),
      .det_q     (det_mask),
      .cov_q     (cov_mask)
   );

   if (WORD_W > NUM_LANES) begin : g_pad_chk
      AST_PAD_LANES_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_word[WORD_W-1:NUM_LANES] == {(WORD_W-NUM_LANES){out_word[0]}})); // R4
      AST_PAD_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (det_mask[WORD_W-1:NUM_LANES] == '0)); // R5
   end
endmodule

// File: tb/fault_sim_eval_tb_top.sv
module fault_sim_eval_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vec_valid = 1'b0;
   logic [4:0]  vec_in = '0;
   logic        cov_clear = 1'b0;
   logic        out_valid;
   logic [31:0] out_word, det_mask, cov_mask;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [4:0]  v;
      logic [31:0] word;
      logic [31:0] det;
      logic [31:0] cov;
   } exp_t;
   exp_t sb_q[$];
   logic [31:0] exp_cov = '0;

   always #2.5 clk = ~clk;

   fault_sim_eval dut_i (
      .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_in(vec_in),
      .cov_clear(cov_clear), .out_valid(out_valid), .out_word(out_word),
      .det_mask(det_mask), .cov_mask(cov_mask)
   );

   function automatic bit inj(bit val, int idx, int fn, bit fv);
      return (idx == fn) ? fv : val;
   endfunction

   // Scalar reference: lane 0 good, lane 2k+1 net k s-a-0, lane 2k+2 net k s-a-1 (R2, R3, R4)
   function automatic logic [31:0] model_word(logic [4:0] v);
      logic [31:0] w;
      for (int lane = 0; lane < 32; lane++) begin
         int fn; bit fv; bit a, b, c, d, e, f, g, h, i;
         fn = -1; fv = 0;
         if (lane >= 1 && lane <= 18) begin
            fn = (lane - 1) / 2;
            fv = bit'((lane - 1) % 2);
         end
         a = inj(v[4], 0, fn, fv);
         b = inj(v[3], 1, fn, fv);
         c = inj(v[2], 2, fn, fv);
         d = inj(v[1], 3, fn, fv);
         e = inj(v[0], 4, fn, fv);
         f = inj(b & c, 5, fn, fv);
         g = inj(~(d | e), 6, fn, fv);
         h = inj(~(f & g), 7, fn, fv);
         i = inj(a | h, 8, fn, fv);
         w[lane] = i;
      end
      return w;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: apply one vector, optionally with clear, and push the expected result
   task automatic send(logic [4:0] v, bit clr);
      exp_t it;
      @(negedge clk);
      vec_valid = 1'b1;
      vec_in    = v;
      cov_clear = clr;
      it.v    = v;
      it.word = model_word(v);
      it.det  = it.word ^ {32{it.word[0]}};
      exp_cov = (clr ? 32'h0 : exp_cov) | it.det;
      it.cov  = exp_cov;
      sb_q.push_back(it);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      vec_valid = 1'b0;
      cov_clear = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   // Monitor: pop and compare at the negedge after acceptance (R6)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R6 unexpected out_valid", {31'b0, out_valid}, 32'h0);
         end else begin
            exp_t it;
            it = sb_q.pop_front();
            check(out_word[0] == it.word[0], "R2 good lane", out_word, it.word);
            check(out_word == it.word, "R3 fault lanes", out_word, it.word);
            check(out_word[31:19] == {13{out_word[0]}}, "R4 pad lanes", out_word, it.word);
            check(det_mask == it.det, "R5 detect mask", det_mask, it.det);
            check(cov_mask == it.cov, "R8 coverage", cov_mask, it.cov);
            if (it.v == 5'b01100) begin
               check(det_mask[13] == 1'b1 && out_word[0] == 1'b0 && out_word[13] == 1'b1,
                     "R7 g s-a-0 lane 13", out_word, it.word);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] held_w, held_d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_word == 0 && det_mask == 0 && cov_mask == 0,
            "R1 reset state", out_word | det_mask | cov_mask | {31'b0, out_valid}, 32'h0);

      // Exhaustive vectors, back to back
      for (int v = 0; v < 32; v++) send(5'(v), 1'b0);
      idle(3);
      check(out_valid == 1'b0, "R6 idle no valid", {31'b0, out_valid}, 32'h0);
      held_w = out_word;
      held_d = det_mask;
      idle(4);
      check(out_word == held_w, "R6 word held", out_word, held_w);
      check(det_mask == held_d, "R6 det held", det_mask, held_d);
      check(cov_mask == exp_cov, "R8 final coverage", cov_mask, exp_cov);

      // Clear alone
      @(negedge clk);
      cov_clear = 1'b1;
      exp_cov = 32'h0;
      @(negedge clk);
      cov_clear = 1'b0;
      check(cov_mask == 32'h0, "R9 clear alone", cov_mask, 32'h0);
      check(out_word == held_w, "R6 clear leaves word", out_word, held_w);

      // Accumulate a few, then clear together with a vector
      send(5'b01100, 1'b0);
      idle(2);
      send(5'b00000, 1'b0);
      send(5'b10111, 1'b0);
      idle(2);
      send(5'b00110, 1'b1);
      idle(3);
      check(sb_q.size() == 0, "R6 all results seen", 32'(sb_q.size()), 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule